// File: doc/BRIEF.md
# Bus-Activity Watchdog Timer

This block watches a host processor through the traffic it puts on a two-wire serial bus, rather than through a dedicated kick pin. Clock and data lines are sampled with the system clock and passed through a synchronizer. From the synchronized copies the block finds start and stop conditions, and it checks whether a clock pulse came between them. A frame that has a start, at least one clock low-then-high pulse and then a stop counts as a restart. Any ordinary read or write transfer, to any address, contains such a frame.

A free-running millisecond tick drives an interval counter. A two-bit select picks the window length or turns the watchdog off. When the window passes without a restart, the active-low watchdog output falls. It stays low until the next valid restart frame. Address decoding and the storage of the select bits are handled by neighbouring logic.

Top module: `wdg_bus_watchdog`

## Requirements
- R1: While reset is applied, and once it is released, `wdo_no` is high and the interval counter is zero. Reset is asserted asynchronously and released through a two-flop synchronizer.
- R2: `win_sel_i` selects the window: 2'b00 gives 25 ticks, 2'b01 gives 200 ticks, 2'b10 gives 1400 ticks, and 2'b11 turns the watchdog off. The tick counts are parameters.
- R3: Counting starts from zero after a restart or a clear. `wdo_no` falls on the clock edge at which the window's last tick is taken. A tick is counted only in a cycle where `tick_ms_i` is high.
- R4: Both lines pass through a two-stage synchronizer. A start is SDA going from 1 to 0 while SCL is 1. A stop is SDA going from 0 to 1 while SCL is 1.
- R5: A stop that follows a start and at least one SCL fall-then-rise restarts the watchdog. On the edge at which the stop is seen, the counter is cleared and `wdo_no` returns high.
- R6: A stop that follows a start with no SCL low-then-high pulse between them does not restart the counter.
- R7: A stop that is not preceded by a start does not restart the counter, and does not release an active watchdog output.
- R8: Once `wdo_no` is low it stays low, whatever the ticks do, until a valid restart frame arrives.
- R9: With select 2'b11, `wdo_no` is high and the counter stays at zero. When a window is selected again, counting starts from zero.
- R10: A change of `win_sel_i` clears the counter on the next clock edge.
- R11: A complete byte transfer restarts the watchdog. Such a transfer is a start, nine SCL pulses with SDA changing only while SCL is low, and a stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial bus clock line, asynchronous |
| sda_i | input | 1 | Serial bus data line, asynchronous |
| win_sel_i | input | 2 | Window select (00/01/10 = short/mid/long, 11 = off) |
| tick_ms_i | input | 1 | One-cycle millisecond tick, counting enable |
| wdo_no | output | 1 | Watchdog output, low when the window expired |

## Verification
The hardest case to reach is a stop condition that arrives while the counter is near its limit but the frame lacks a required part. Such a stop has to be told apart from a real restart purely by when the output falls. The stimulus restarts the counter first, so the counting state is known. It then sends a malformed frame at a known offset and samples the output in a window where a wrongly accepted stop would still hold it high. A select change while the count is far above the new, shorter limit is staged the same way. Without the clear, the counter would run past the compare value.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  typedef enum logic [1:0] {
    WIN_SHORT = 2'b00,
    WIN_MID   = 2'b01,
    WIN_LONG  = 2'b10,
    WIN_OFF   = 2'b11
  } win_sel_e;

  typedef enum logic [1:0] {
    TRK_IDLE  = 2'd0,
    TRK_OPEN  = 2'd1,
    TRK_LOW   = 2'd2,
    TRK_ARMED = 2'd3
  } trk_state_e;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/wdg_rst_sync.sv
module wdg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/wdg_line_sync.sv
module wdg_line_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned LINES  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] din_i,
  output logic [LINES-1:0] dout_o,
  output logic [LINES-1:0] dprev_o
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;
    logic              prev_q;

    always_comb chain_d = {chain_q[STAGES-2:0], din_i[g]};

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        chain_q <= '1;
        prev_q  <= 1'b1;
      end else begin
        chain_q <= chain_d;
        prev_q  <= chain_q[STAGES-1];
      end
    end

    assign dout_o[g]  = chain_q[STAGES-1];
    assign dprev_o[g] = prev_q;
  end
endmodule

// File: rtl/wdg_frame_track.sv
module wdg_frame_track
  import wdg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic scl_prev_i,
  input  logic sda_i,
  input  logic sda_prev_i,
  output logic kick_o,
  output logic armed_o
);
  trk_state_e state_q, state_d;
  logic start_c, stop_c, scl_fall_c, scl_rise_c;

  always_comb begin
    start_c    = scl_i & sda_prev_i & ~sda_i;
    stop_c     = scl_i & ~sda_prev_i & sda_i;
    scl_fall_c = scl_prev_i & ~scl_i;
    scl_rise_c = ~scl_prev_i & scl_i;
  end

  always_comb begin
    state_d = state_q;
    if (start_c)     state_d = TRK_OPEN;
    else if (stop_c) state_d = TRK_IDLE;
    else begin
      case (state_q)
        TRK_OPEN: if (scl_fall_c) state_d = TRK_LOW;
        TRK_LOW:  if (scl_rise_c) state_d = TRK_ARMED;
        default:  state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= TRK_IDLE;
    else         state_q <= state_d;
  end

  assign armed_o = (state_q == TRK_ARMED);
  assign kick_o  = stop_c & armed_o;
endmodule

// File: rtl/wdg_interval_timer.sv
module wdg_interval_timer
  import wdg_pkg::*;
#(
  parameter int unsigned CNT_W     = 11,
  parameter int unsigned LIM_SHORT = 25,
  parameter int unsigned LIM_MID   = 200,
  parameter int unsigned LIM_LONG  = 1400
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [1:0]       sel_i,
  input  logic             kick_i,
  output logic             expired_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [1:0]       sel_q_o,
  output logic [CNT_W-1:0] limit_o
);
  win_sel_e         sel_c;
  logic [1:0]       sel_q;
  logic [CNT_W-1:0] cnt_q, cnt_d, limit_c;
  logic             exp_q, exp_d;

  assign sel_c = win_sel_e'(sel_i);

  always_comb begin
    case (sel_c)
      WIN_SHORT: limit_c = CNT_W'(LIM_SHORT);
      WIN_MID:   limit_c = CNT_W'(LIM_MID);
      WIN_LONG:  limit_c = CNT_W'(LIM_LONG);
      default:   limit_c = '0;
    endcase
  end

  always_comb begin
    cnt_d = cnt_q;
    exp_d = exp_q;
    if (kick_i) begin
      cnt_d = '0;
      exp_d = 1'b0;
    end else if (sel_c == WIN_OFF) begin
      cnt_d = '0;
      exp_d = 1'b0;
    end else if (sel_i != sel_q) begin
      cnt_d = '0;
    end else if (!exp_q && tick_i) begin
      if (cnt_q == limit_c - 1'b1) exp_d = 1'b1;
      else                         cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
      sel_q <= 2'b00;
    end else begin
      cnt_q <= cnt_d;
      exp_q <= exp_d;
      sel_q <= sel_i;
    end
  end

  assign expired_o = exp_q;
  assign cnt_o     = cnt_q;
  assign sel_q_o   = sel_q;
  assign limit_o   = limit_c;
endmodule

// File: rtl/wdg_bus_watchdog.sv
module wdg_bus_watchdog
  import wdg_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned LIM_SHORT   = 25,
  parameter int unsigned LIM_MID     = 200,
  parameter int unsigned LIM_LONG    = 1400
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] win_sel_i,
  input  logic       tick_ms_i,
  output logic       wdo_no
);
  localparam int unsigned LIM_MAX = max3(LIM_SHORT, LIM_MID, LIM_LONG);
  localparam int unsigned CNT_W   = $clog2(LIM_MAX + 1);

  logic             rst_sn;
  logic [1:0]       line_now, line_prev;
  logic             kick_w, armed_w, expired_w;
  logic [CNT_W-1:0] cnt_w, limit_w;
  logic [1:0]       sel_q_w;

  wdg_rst_sync #(.STAGES(2)) u_rst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_sn)
  );

  wdg_line_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_sn),
    .din_i  ({sda_i, scl_i}),
    .dout_o (line_now),
    .dprev_o(line_prev)
  );

  wdg_frame_track u_trk (
    .clk_i     (clk_i),
    .rst_ni    (rst_sn),
    .scl_i     (line_now[0]),
    .scl_prev_i(line_prev[0]),
    .sda_i     (line_now[1]),
    .sda_prev_i(line_prev[1]),
    .kick_o    (kick_w),
    .armed_o   (armed_w)
  );

  wdg_interval_timer #(
    .CNT_W(CNT_W), .LIM_SHORT(LIM_SHORT), .LIM_MID(LIM_MID), .LIM_LONG(LIM_LONG)
  ) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_sn),
    .tick_i   (tick_ms_i),
    .sel_i    (win_sel_i),
    .kick_i   (kick_w),
    .expired_o(expired_w),
    .cnt_o    (cnt_w),
    .sel_q_o  (sel_q_w),
    .limit_o  (limit_w)
  );

  assign wdo_no = ~expired_w;
endmodule

// File: rtl/wdg_bus_watchdog_chk.sv
module wdg_bus_watchdog_chk #(
  parameter int unsigned CNT_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       sel,
  input logic [1:0]       sel_q,
  input logic             kick,
  input logic             armed,
  input logic             tick,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] limit,
  input logic             wdo_n
);
  // R1: output released after reset with empty counter
  p_reset_idle_r1: assert property (@(posedge clk) $rose(rst_n) |-> (wdo_n && cnt == '0));

  // R2: counter never reaches the selected limit while select is stable
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == sel_q && sel != 2'b11) |-> (cnt < limit));

  // R3: output only falls on a counted tick at the last count
  p_fall_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdo_n) |-> ($past(tick) && $past(cnt) == $past(limit) - 1'b1));

  // R5: restart releases the output and empties the counter
  p_kick_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (wdo_n && cnt == '0));

  // R6: a restart comes only from an armed frame that then closes
  p_disarm_after_kick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !armed);

  // R8: active output holds without a restart
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wdo_n && !kick && sel != 2'b11) |=> !wdo_n);

  // R9: off setting keeps the output inactive
  p_off_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'b11) |=> (wdo_n && cnt == '0));

  // R10: a select change clears the counter
  p_selchg_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != sel_q) |=> (cnt == '0));
endmodule

bind wdg_bus_watchdog wdg_bus_watchdog_chk #(.CNT_W(CNT_W)) u_chk (
  .clk  (clk_i),
  .rst_n(rst_sn),
  .sel  (win_sel_i),
  .sel_q(sel_q_w),
  .kick (kick_w),
  .armed(armed_w),
  .tick (tick_ms_i),
  .cnt  (cnt_w),
  .limit(limit_w),
  .wdo_n(wdo_no)
);

// File: tb/sim_wdg_bus_watchdog.sv
module sim_wdg_bus_watchdog;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       scl_i = 1'b1;
  logic       sda_i = 1'b1;
  logic [1:0] win_sel_i = 2'b00;
  logic       tick_ms_i = 1'b0;
  logic       wdo_no;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int tick_div = 1;
  bit done = 0;
  string cur_req = "R1";

  wdg_bus_watchdog u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_i(sda_i),
    .win_sel_i(win_sel_i), .tick_ms_i(tick_ms_i), .wdo_no(wdo_no)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // ---------------- reference model ----------------
  int m_r1, m_r2;
  int m_s[3];
  int m_d[3];
  int m_phase;   // 0 idle, 1 started, 2 clock low seen, 3 clock pulse complete
  int m_cnt, m_exp, m_selq;

  function automatic int win_len(input logic [1:0] s);
    case (s)
      2'b00: return 25;
      2'b01: return 200;
      2'b10: return 1400;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_r1 = 0; m_r2 = 0;
      for (int i = 0; i < 3; i++) begin m_s[i] = 1; m_d[i] = 1; end
      m_phase = 0; m_cnt = 0; m_exp = 0; m_selq = 0;
    end else begin
      if (m_r2 != 0) begin
        bit st, sp, fl, rs, kk;
        st = (m_s[1] == 1) && (m_d[2] == 1) && (m_d[1] == 0);
        sp = (m_s[1] == 1) && (m_d[2] == 0) && (m_d[1] == 1);
        fl = (m_s[2] == 1) && (m_s[1] == 0);
        rs = (m_s[2] == 0) && (m_s[1] == 1);
        kk = sp && (m_phase == 3);
        if (st) m_phase = 1;
        else if (sp) m_phase = 0;
        else if (m_phase == 1 && fl) m_phase = 2;
        else if (m_phase == 2 && rs) m_phase = 3;
        if (kk || win_sel_i == 2'b11) begin
          m_cnt = 0; m_exp = 0;
        end else if (int'(win_sel_i) != m_selq) begin
          m_cnt = 0;
        end else if (m_exp == 0 && tick_ms_i) begin
          m_cnt++;
          if (m_cnt >= win_len(win_sel_i)) begin m_exp = 1; m_cnt--; end
        end
        m_selq = int'(win_sel_i);
        m_s[2] = m_s[1]; m_s[1] = m_s[0]; m_s[0] = int'(scl_i);
        m_d[2] = m_d[1]; m_d[1] = m_d[0]; m_d[0] = int'(sda_i);
      end
      m_r2 = m_r1; m_r1 = 1;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk_i) begin
    cyc++;
    tick_ms_i <= ((cyc % tick_div) == 0);
    if (!done && cyc > 2) begin
      checks++;
      if (wdo_no !== (m_exp == 0)) begin
        fails++;
        $display("FAIL %s (model, cycle %0d): wdo_no=%0b expected %0b",
                 cur_req, cyc, wdo_no, (m_exp == 0));
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(negedge clk_i) begin
    if (!done && cyc > WATCHDOG_CYCLES) begin
      checks++; fails++;
      $display("FAIL watchdog: cycles=%0d expected below %0d", cyc, WATCHDOG_CYCLES);
      finish_run();
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic chk(input string req, input logic exp);
    checks++;
    if (wdo_no !== exp) begin
      fails++;
      $display("FAIL %s: wdo_no=%0b expected %0b", req, wdo_no, exp);
    end
  endtask

  task automatic bus(input logic s, input logic d);
    scl_i = s; sda_i = d;
    wait_cyc(4);
  endtask

  task automatic kick_min();
    bus(1'b1, 1'b0);   // start
    bus(1'b0, 1'b0);   // clock low
    bus(1'b1, 1'b0);   // clock high
    bus(1'b1, 1'b1);   // stop
  endtask

  task automatic byte_xfer(input logic [8:0] bits);
    bus(1'b1, 1'b0);
    for (int i = 8; i >= 0; i--) begin
      bus(1'b0, bits[i]);
      bus(1'b1, bits[i]);
    end
    bus(1'b0, 1'b0);
    bus(1'b1, 1'b0);
    bus(1'b1, 1'b1);
  endtask

  initial begin
    @(negedge clk_i);
    wait_cyc(3);
    chk("R1 in reset", 1'b1);
    rst_ni = 1'b1;
    wait_cyc(3);
    chk("R1 after release", 1'b1);

    // R2/R3: short window with a tick every cycle
    cur_req = "R3";
    wait_cyc(17);
    chk("R3 before short window ends", 1'b1);
    wait_cyc(15);
    chk("R2 short window expired", 1'b0);

    // R8: stays low with ticks running
    cur_req = "R8";
    wait_cyc(50);
    chk("R8 held low", 1'b0);

    // R7: stop with no start
    cur_req = "R7";
    bus(1'b0, 1'b1); bus(1'b0, 1'b0); bus(1'b1, 1'b0); bus(1'b1, 1'b1);
    wait_cyc(3);
    chk("R7 lone stop ignored", 1'b0);

    // R4/R5: minimal restart frame
    cur_req = "R5";
    kick_min();
    chk("R5 restart releases output", 1'b1);
    wait_cyc(20);
    chk("R4 count restarted from zero", 1'b1);

    // R6: start then stop with no clock pulse
    cur_req = "R6";
    kick_min();
    wait_cyc(10);
    bus(1'b1, 1'b0); bus(1'b1, 1'b1);
    wait_cyc(12);
    chk("R6 short frame ignored", 1'b0);

    // R11: full byte transfer
    cur_req = "R11";
    byte_xfer(9'b1010_0001_0);
    chk("R11 transfer restarts", 1'b1);
    wait_cyc(40);
    chk("R11 expires again", 1'b0);

    // R10: select change with the count above the new limit
    cur_req = "R10";
    win_sel_i = 2'b01;
    wait_cyc(2);
    kick_min();
    wait_cyc(190);
    chk("R10 mid window still running", 1'b1);
    win_sel_i = 2'b00;
    wait_cyc(15);
    chk("R10 cleared on select change", 1'b1);
    wait_cyc(20);
    chk("R10 short window after change", 1'b0);

    // R9: off setting
    cur_req = "R9";
    win_sel_i = 2'b11;
    wait_cyc(3);
    chk("R9 off releases output", 1'b1);
    wait_cyc(2000);
    chk("R9 off never expires", 1'b1);
    win_sel_i = 2'b00;
    wait_cyc(15);
    chk("R9 recount from zero", 1'b1);
    wait_cyc(20);
    chk("R9 expires after reselect", 1'b0);

    // R2: long and mid windows
    cur_req = "R2";
    win_sel_i = 2'b10;
    wait_cyc(2);
    kick_min();
    wait_cyc(1350);
    chk("R2 long window running", 1'b1);
    wait_cyc(100);
    chk("R2 long window expired", 1'b0);
    win_sel_i = 2'b01;
    wait_cyc(2);
    kick_min();
    wait_cyc(180);
    chk("R2 mid window running", 1'b1);
    wait_cyc(50);
    chk("R2 mid window expired", 1'b0);

    // R3: sparse ticks
    cur_req = "R3";
    win_sel_i = 2'b00;
    tick_div = 4;
    wait_cyc(2);
    kick_min();
    wait_cyc(80);
    chk("R3 sparse ticks running", 1'b1);
    wait_cyc(40);
    chk("R3 sparse ticks expired", 1'b0);

    finish_run();
  end
endmodule